// File: doc/BRIEF.md
# Variable-Page-Size Translation Buffer with Probe

This block is a small fully associative address translation buffer. Each of its entries maps a pair of neighbouring virtual pages, one even and one odd, onto two independent physical frames. Every entry carries its own page-size mask, so one entry can cover a 4 KB page pair while another covers a megabyte pair. The smallest mapping is a 4 KB pair; sub-4 KB pages do not exist.

Software-style loading goes through a write port. That port takes an index and four register images: a high word with the virtual page and address-space identifier (ASID), a page-size mask, and one low word for each half. A translate port accepts a virtual address, the current ASID and a read/write flag. One cycle later it answers with a physical address and exactly one outcome: hit, miss, invalid fault or modified fault. A probe port takes a high-word image and, one cycle later, returns the index of the lowest-numbered matching entry, or a failure flag.

Top module: `vptlb`

## Requirements
- R1: Synchronous active-low reset clears every entry to virtual page 0, ASID 0, mask 0, not global, both halves invalid and clean. After reset, a translation with ASID 0 inside the first 8 KB reports invalid, and a translation with any other ASID misses.
- R2: An entry's effective mask is its stored mask ORed with 0x1FFF. Address bits covered by the effective mask take no part in the match. All remaining bits of the address must equal the entry's stored virtual page.
- R3: An entry matches only if it is global or its 8-bit ASID equals the requested ASID. A global entry matches under every ASID.
- R4: The half is chosen by the address bit at the top of the effective mask, the bit in mask AND NOT(mask >> 1). A 0 selects the even half and a 1 selects the odd half.
- R5: The physical address is the chosen half's 20-bit frame number placed at bits 31:12, ORed with the address bits covered by (mask >> 1).
- R6: A matching access whose chosen half is not valid reports an invalid fault, whatever the read/write flag.
- R7: A read of a valid half hits. A write hits only if the chosen half's dirty bit is set. A write to a valid clean half reports a modified fault. A read never reports a modified fault.
- R8: Each translate request produces a response one clock later with the response-valid flag set and exactly one of hit, miss, invalid and modified set. With no request, response-valid is low. Outcome codes in the bench are {hit,miss,invalid,modified} = 1000, 0100, 0010, 0001.
- R9: A probe answers one clock later with the lowest matching index in bits 3:0 and zeros above. When no entry matches, the answer is 0x80000000 (bit 31 set, index zero). The match uses the same masked page and ASID/global rule, with the ASID taken from bits 7:0 of the probe word.
- R10: A write stores the virtual page from bits 31:13 of the high word and the ASID from bits 7:0. The stored mask keeps only bits 28:13 of the mask word. The global bit is the AND of bit 0 of the two low words.
- R11: In each low word, bits 25:6 are the frame number, bit 2 is dirty, bit 1 is valid and bit 0 is global. Bits 31:26 and 5:3 are ignored.
- R12: When several entries match a translation, the lowest-numbered one supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load the entry selected by wr_idx |
| wr_idx | input | 4 | Entry index to load |
| wr_hi | input | 32 | Virtual page (31:13) and ASID (7:0) image |
| wr_pmask | input | 32 | Page-size mask image |
| wr_lo0 | input | 32 | Even-half frame, dirty, valid, global image |
| wr_lo1 | input | 32 | Odd-half frame, dirty, valid, global image |
| xl_req | input | 1 | Translate request |
| xl_vaddr | input | 32 | Virtual address to translate |
| xl_asid | input | 8 | Current ASID |
| xl_write | input | 1 | 1 for a store access, 0 for a load |
| xl_valid | output | 1 | Translate response present |
| xl_hit | output | 1 | Translation succeeded |
| xl_miss | output | 1 | No entry matched |
| xl_invalid | output | 1 | Chosen half not valid |
| xl_modified | output | 1 | Write to a clean half |
| xl_paddr | output | 32 | Physical address, meaningful on hit |
| pb_req | input | 1 | Probe request |
| pb_hi | input | 32 | Probe word: virtual page and ASID |
| pb_valid | output | 1 | Probe response present |
| pb_result | output | 32 | Matching index, or bit 31 set on failure |

## Verification
The buffer is loaded with entries of three page sizes (4 KB, 16 KB and 1 MB pairs), a mix of global and private entries, halves in every valid/dirty combination, and two entries that overlap. Address sweeps step across and past each mapped region. They separate the match boundary of the masked compare from the even/odd split, and the split from the offset bits carried into the physical address. Each address is tried under four ASIDs and both access directions, which pulls ASID filtering apart from the dirty-bit rule. Directed loads with junk in the ignored mask and low-word bits, together with probe words that match nothing, show that clamping, field extraction, lowest-index priority and the failure encoding all act as required.

// File: rtl/vptlb_pkg.sv
// Shared widths, field positions and the entry record for the variable
// page-size translation buffer. Assumes 32-bit virtual and physical spaces
// with a 4 KB minimum page, so an entry minimally covers an 8 KB pair.
package vptlb_pkg;
    localparam int VA_W    = 32;
    localparam int ASID_W  = 8;
    localparam int PFN_W   = 20;
    localparam int PAGE_SH = 12;
    localparam int PA_W    = PFN_W + PAGE_SH;

    // Bits always ignored by the compare: offset plus the half-select bit.
    localparam logic [VA_W-1:0] MIN_MASK = VA_W'((64'd1 << (PAGE_SH + 1)) - 64'd1);
    // Bits of a mask image that may be stored.
    localparam logic [VA_W-1:0] PM_KEEP  = VA_W'(32'h1FFF_FFFF) & ~MIN_MASK;

    // Low-word field positions.
    localparam int LO_G       = 0;
    localparam int LO_V       = 1;
    localparam int LO_D       = 2;
    localparam int LO_PFN_LSB = 6;

    typedef struct packed {
        logic [VA_W-1:0]   vpn;
        logic [ASID_W-1:0] asid;
        logic [VA_W-1:0]   pmask;
        logic              glob;
        logic [PFN_W-1:0]  pfn0;
        logic [PFN_W-1:0]  pfn1;
        logic              v0;
        logic              v1;
        logic              d0;
        logic              d1;
    } tlb_entry_t;

    // Effective per-entry mask used by every compare.
    function automatic logic [VA_W-1:0] eff_mask(input logic [VA_W-1:0] pm);
        return pm | MIN_MASK;
    endfunction
endpackage

// File: rtl/vptlb_store.sv
// Entry storage. Holds N entries and decodes the four register images into
// entry fields on a write. Assumes at most one write per cycle. Readers see
// the new contents from the cycle after the write.
module vptlb_store
    import vptlb_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_hi,
    input  logic [VA_W-1:0]  wr_pmask,
    input  logic [31:0]      wr_lo0,
    input  logic [31:0]      wr_lo1,
    output tlb_entry_t       ents [N]
);
    tlb_entry_t new_ent;
    logic       unused_store_bits;

    // Decode the register images into one entry record.
    always_comb begin
        new_ent       = '0;
        new_ent.vpn   = wr_hi & ~MIN_MASK;
        new_ent.asid  = wr_hi[ASID_W-1:0];
        new_ent.pmask = wr_pmask & PM_KEEP;
        new_ent.glob  = wr_lo0[LO_G] & wr_lo1[LO_G];
        new_ent.pfn0  = wr_lo0[LO_PFN_LSB +: PFN_W];
        new_ent.pfn1  = wr_lo1[LO_PFN_LSB +: PFN_W];
        new_ent.v0    = wr_lo0[LO_V];
        new_ent.v1    = wr_lo1[LO_V];
        new_ent.d0    = wr_lo0[LO_D];
        new_ent.d1    = wr_lo1[LO_D];
    end

    assign unused_store_bits = ^{wr_lo0[31:LO_PFN_LSB+PFN_W], wr_lo0[LO_PFN_LSB-1:LO_D+1],
                                 wr_lo1[31:LO_PFN_LSB+PFN_W], wr_lo1[LO_PFN_LSB-1:LO_D+1],
                                 wr_hi[PAGE_SH:ASID_W]};

    for (genvar i = 0; i < N; i++) begin : g_ent
        // Clear on reset, load when this entry is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ents[i] <= new_ent;
            end
        end
    end
endmodule

// File: rtl/vptlb_cam.sv
// Parallel compare of one lookup against every entry. Produces one match
// bit per entry from the masked page compare and the ASID/global rule.
// Purely combinational; assumes the caller registers what it needs.
module vptlb_cam
    import vptlb_pkg::*;
#(
    parameter int N = 16
) (
    input  tlb_entry_t        ents [N],
    input  logic [VA_W-1:0]   addr,
    input  logic [ASID_W-1:0] asid,
    output logic [N-1:0]      match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        logic [VA_W-1:0] m;
        logic            asid_ok;
        logic            page_ok;
        logic            unused_cam_bits;

        // Masked page compare and address-space filter for entry i.
        always_comb begin
            m       = eff_mask(ents[i].pmask);
            asid_ok = ents[i].glob || (ents[i].asid == asid);
            page_ok = (addr & ~m) == (ents[i].vpn & ~m);
            match[i] = asid_ok && page_ok;
        end

        assign unused_cam_bits = ^{ents[i].pfn0, ents[i].pfn1, ents[i].v0,
                                   ents[i].v1, ents[i].d0, ents[i].d1};
    end
endmodule

// File: rtl/vptlb_prio.sv
// Lowest-index-first priority encoder over a match vector. Reports whether
// any bit is set and the index of the lowest set bit (zero when none).
module vptlb_prio #(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     match,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vptlb_xlate.sv
// Translation stage. Picks the lowest matching entry, selects its even or
// odd half from the top bit of its mask, forms the physical address and
// classifies the access. All results are registered: one cycle of latency.
module vptlb_xlate
    import vptlb_pkg::*;
#(
    parameter int N = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [VA_W-1:0] vaddr,
    input  logic            write,
    input  tlb_entry_t      ents [N],
    input  logic [N-1:0]    match,
    output logic            valid_o,
    output logic            hit_o,
    output logic            miss_o,
    output logic            inv_o,
    output logic            mod_o,
    output logic [PA_W-1:0] paddr_o
);
    logic             found;
    logic [IDX_W-1:0] idx;
    tlb_entry_t       sel;
    logic [VA_W-1:0]  mask;
    logic [VA_W-1:0]  half_bit;
    logic             odd;
    logic [PFN_W-1:0] pfn;
    logic             half_v;
    logic             half_d;
    logic [PA_W-1:0]  pa_c;
    logic             hit_c;
    logic             miss_c;
    logic             inv_c;
    logic             mod_c;
    logic             unused_xlate_bits;

    vptlb_prio #(.N(N)) prio_i (
        .match (match),
        .found (found),
        .idx   (idx)
    );

    // Half selection, address formation and outcome classification.
    always_comb begin
        sel      = ents[idx];
        mask     = eff_mask(sel.pmask);
        half_bit = mask & ~(mask >> 1);
        odd      = |(vaddr & half_bit);
        pfn      = odd ? sel.pfn1 : sel.pfn0;
        half_v   = odd ? sel.v1   : sel.v0;
        half_d   = odd ? sel.d1   : sel.d0;
        pa_c     = {pfn, {PAGE_SH{1'b0}}} | PA_W'(vaddr & (mask >> 1));
        miss_c   = !found;
        inv_c    = found && !half_v;
        mod_c    = found && half_v && write && !half_d;
        hit_c    = found && half_v && (!write || half_d);
    end

    assign unused_xlate_bits = ^{sel.vpn, sel.asid, sel.glob};

    // Register the response; flags stay low between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            hit_o   <= 1'b0;
            miss_o  <= 1'b0;
            inv_o   <= 1'b0;
            mod_o   <= 1'b0;
            paddr_o <= '0;
        end else begin
            valid_o <= req;
            hit_o   <= req && hit_c;
            miss_o  <= req && miss_c;
            inv_o   <= req && inv_c;
            mod_o   <= req && mod_c;
            if (req) begin
                paddr_o <= pa_c;
            end
        end
    end

    // R8
    xl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($countones({hit_o, miss_o, inv_o, mod_o}) == 1));

    // R8
    xl_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid_o);

    // R8
    xl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ({valid_o, hit_o, miss_o, inv_o, mod_o} == 5'b0));

    // R7
    xl_read_no_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !write) |=> !mod_o);
endmodule

// File: rtl/vptlb.sv
// Top level of the variable page-size translation buffer. Ties the entry
// store to two compare arrays, one for translation and one for probing.
// Assumes writes and lookups issued in the same cycle see the old contents.
module vptlb
    import vptlb_pkg::*;
#(
    parameter int N    = 16,
    parameter int PB_W = 32,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_hi,
    input  logic [31:0]      wr_pmask,
    input  logic [31:0]      wr_lo0,
    input  logic [31:0]      wr_lo1,
    input  logic             xl_req,
    input  logic [31:0]      xl_vaddr,
    input  logic [7:0]       xl_asid,
    input  logic             xl_write,
    output logic             xl_valid,
    output logic             xl_hit,
    output logic             xl_miss,
    output logic             xl_invalid,
    output logic             xl_modified,
    output logic [31:0]      xl_paddr,
    input  logic             pb_req,
    input  logic [31:0]      pb_hi,
    output logic             pb_valid,
    output logic [PB_W-1:0]  pb_result
);
    tlb_entry_t       ents [N];
    logic [N-1:0]     xl_match;
    logic [N-1:0]     pb_match;
    logic             pb_found;
    logic [IDX_W-1:0] pb_idx;
    logic [PB_W-1:0]  pb_res_c;

    vptlb_store #(.N(N)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_hi    (wr_hi),
        .wr_pmask (wr_pmask),
        .wr_lo0   (wr_lo0),
        .wr_lo1   (wr_lo1),
        .ents     (ents)
    );

    vptlb_cam #(.N(N)) xl_cam_i (
        .ents  (ents),
        .addr  (xl_vaddr),
        .asid  (xl_asid),
        .match (xl_match)
    );

    vptlb_xlate #(.N(N)) xlate_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (xl_req),
        .vaddr   (xl_vaddr),
        .write   (xl_write),
        .ents    (ents),
        .match   (xl_match),
        .valid_o (xl_valid),
        .hit_o   (xl_hit),
        .miss_o  (xl_miss),
        .inv_o   (xl_invalid),
        .mod_o   (xl_modified),
        .paddr_o (xl_paddr)
    );

    vptlb_cam #(.N(N)) pb_cam_i (
        .ents  (ents),
        .addr  (pb_hi),
        .asid  (pb_hi[ASID_W-1:0]),
        .match (pb_match)
    );

    vptlb_prio #(.N(N)) pb_prio_i (
        .match (pb_match),
        .found (pb_found),
        .idx   (pb_idx)
    );

    // Build the probe answer: index on success, top flag alone on failure.
    always_comb begin
        pb_res_c = '0;
        if (pb_found) begin
            pb_res_c[IDX_W-1:0] = pb_idx;
        end else begin
            pb_res_c[PB_W-1] = 1'b1;
        end
    end

    // Register the probe answer for a one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_valid  <= 1'b0;
            pb_result <= '0;
        end else begin
            pb_valid <= pb_req;
            if (pb_req) begin
                pb_result <= pb_res_c;
            end
        end
    end

    // R9
    pb_fail_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_valid && pb_result[PB_W-1]) |-> (pb_result[PB_W-2:0] == '0));

    // R9
    pb_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_valid && !pb_result[PB_W-1]) |-> (pb_result[PB_W-2:IDX_W] == '0));

    // R9
    pb_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pb_req |=> pb_valid);
endmodule

// File: tb/vptlb_tb_top.sv
// Self-checking bench: directed corner cases plus address/ASID/direction
// sweeps compared against an arithmetic model built from the requirements.
module vptlb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_hi = '0, wr_pmask = '0, wr_lo0 = '0, wr_lo1 = '0;
    logic        xl_req = 1'b0;
    logic [31:0] xl_vaddr = '0;
    logic [7:0]  xl_asid = '0;
    logic        xl_write = 1'b0;
    logic        xl_valid, xl_hit, xl_miss, xl_invalid, xl_modified;
    logic [31:0] xl_paddr;
    logic        pb_req = 1'b0;
    logic [31:0] pb_hi = '0;
    logic        pb_valid;
    logic [31:0] pb_result;

    int tests = 0;
    int fails = 0;

    // model state
    logic [31:0] m_vpn [16];
    logic [7:0]  m_asid [16];
    logic [31:0] m_pm [16];
    logic        m_g [16];
    logic [19:0] m_pfn0 [16], m_pfn1 [16];
    logic        m_v0 [16], m_v1 [16], m_d0 [16], m_d1 [16];

    always #5 clk = ~clk;

    vptlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_pmask(wr_pmask),
        .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_asid(xl_asid), .xl_write(xl_write),
        .xl_valid(xl_valid), .xl_hit(xl_hit), .xl_miss(xl_miss),
        .xl_invalid(xl_invalid), .xl_modified(xl_modified), .xl_paddr(xl_paddr),
        .pb_req(pb_req), .pb_hi(pb_hi), .pb_valid(pb_valid), .pb_result(pb_result)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] lo(input logic [19:0] pfn, input bit d, input bit v, input bit g);
        return ({12'b0, pfn} << 6) | (32'(d) << 2) | (32'(v) << 1) | 32'(g);
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            m_vpn[i] = '0; m_asid[i] = '0; m_pm[i] = '0; m_g[i] = 1'b0;
            m_pfn0[i] = '0; m_pfn1[i] = '0;
            m_v0[i] = 1'b0; m_v1[i] = 1'b0; m_d0[i] = 1'b0; m_d1[i] = 1'b0;
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] hi, input logic [31:0] pm,
                      input logic [31:0] l0, input logic [31:0] l1);
        wr_idx = 4'(idx); wr_hi = hi; wr_pmask = pm; wr_lo0 = l0; wr_lo1 = l1; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        m_vpn[idx]  = hi & 32'hFFFF_E000;
        m_asid[idx] = hi[7:0];
        m_pm[idx]   = pm & 32'h1FFF_E000;
        m_g[idx]    = l0[0] & l1[0];
        m_pfn0[idx] = l0[25:6]; m_pfn1[idx] = l1[25:6];
        m_v0[idx] = l0[1]; m_v1[idx] = l1[1];
        m_d0[idx] = l0[2]; m_d1[idx] = l1[2];
    endtask

    function automatic int model_match(input logic [31:0] a, input logic [7:0] asid);
        for (int i = 0; i < 16; i++) begin
            logic [31:0] mk;
            mk = m_pm[i] | 32'h1FFF;
            if ((m_g[i] || m_asid[i] == asid) && ((a & ~mk) == (m_vpn[i] & ~mk)))
                return i;
        end
        return -1;
    endfunction

    task automatic model_xl(input logic [31:0] a, input logic [7:0] asid, input bit w,
                            output logic [3:0] fl, output logic [31:0] pa);
        int i;
        logic [31:0] mk;
        bit odd, v, d;
        logic [19:0] pfn;
        i = model_match(a, asid);
        pa = '0;
        if (i < 0) begin
            fl = 4'b0100;
        end else begin
            mk  = m_pm[i] | 32'h1FFF;
            odd = (a & mk & ~(mk >> 1)) != 0;
            pfn = odd ? m_pfn1[i] : m_pfn0[i];
            v   = odd ? m_v1[i] : m_v0[i];
            d   = odd ? m_d1[i] : m_d0[i];
            pa  = {pfn, 12'b0} | (a & (mk >> 1));
            if (!v) fl = 4'b0010;
            else if (w && !d) fl = 4'b0001;
            else fl = 4'b1000;
        end
    endtask

    task automatic xl(input logic [31:0] a, input logic [7:0] asid, input bit w,
                      output logic [3:0] fl, output logic [31:0] pa, output logic vld);
        xl_vaddr = a; xl_asid = asid; xl_write = w; xl_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xl_req = 1'b0;
        fl  = {xl_hit, xl_miss, xl_invalid, xl_modified};
        pa  = xl_paddr;
        vld = xl_valid;
    endtask

    task automatic pb(input logic [31:0] hi, output logic [31:0] res);
        pb_hi = hi; pb_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pb_req = 1'b0;
        res = pb_result;
    endtask

    // Directed translation: outcome code and, on hit, physical address.
    task automatic dxl(input string tag, input logic [31:0] a, input logic [7:0] asid,
                       input bit w, input logic [3:0] efl, input logic [31:0] epa);
        logic [3:0] fl; logic [31:0] pa; logic vld;
        xl(a, asid, w, fl, pa, vld);
        chk(tag, {59'b0, vld, fl}, {59'b0, 1'b1, efl});
        if (efl == 4'b1000) chk(tag, {32'b0, pa}, {32'b0, epa});
    endtask

    task automatic dpb(input string tag, input logic [31:0] hi, input logic [31:0] eres);
        logic [31:0] r;
        pb(hi, r);
        chk(tag, {32'b0, r}, {32'b0, eres});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R8 watchdog: actual no finish expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] bases [5];
        logic [7:0]  asids [4];
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 idle response", {63'b0, xl_valid}, 64'd0);
        dxl("R1 reset entry invalid", 32'h0000_1234, 8'h00, 1'b0, 4'b0010, 32'h0);
        dxl("R1 reset asid miss", 32'h0000_0000, 8'h05, 1'b0, 4'b0100, 32'h0);
        dpb("R1 reset probe hit 0", 32'h0000_0000, 32'h0000_0000);
        dpb("R9 reset probe miss", 32'h0000_2005, 32'h8000_0000);

        wr(3,  32'h0040_0001, 32'h0,         lo(20'h00100, 1, 1, 0), lo(20'h00200, 0, 1, 0));
        wr(5,  32'h1000_0003, 32'h0000_6000, lo(20'h00300, 1, 1, 1), lo(20'h003A0, 0, 0, 1));
        wr(9,  32'h2001_2345, 32'hE01F_FFFF, lo(20'h40000, 1, 1, 1), lo(20'h50000, 1, 1, 0));
        wr(7,  32'h3000_0009, 32'h0,         32'hFC00_0000 | lo(20'h00777, 0, 1, 1), lo(20'h00778, 0, 1, 1));
        wr(12, 32'h3000_0011, 32'h0,         lo(20'h00888, 1, 1, 1), lo(20'h00889, 1, 1, 1));

        // Directed corner cases
        dxl("R4 even half 4K", 32'h0040_0ABC, 8'h01, 1'b0, 4'b1000, 32'h0010_0ABC);
        dxl("R4 odd half 4K",  32'h0040_1123, 8'h01, 1'b0, 4'b1000, 32'h0020_0123);
        dxl("R7 write clean half", 32'h0040_1123, 8'h01, 1'b1, 4'b0001, 32'h0);
        dxl("R7 write dirty half", 32'h0040_0004, 8'h01, 1'b1, 4'b1000, 32'h0010_0004);
        dxl("R3 private asid mismatch", 32'h0040_0ABC, 8'h02, 1'b0, 4'b0100, 32'h0);
        dxl("R3 global any asid", 32'h1000_2468, 8'h07, 1'b0, 4'b1000, 32'h0030_2468);
        dxl("R5 16K offset carry", 32'h1000_3FFF, 8'hC3, 1'b1, 4'b1000, 32'h0030_3FFF);
        dxl("R6 invalid odd read", 32'h1000_4000, 8'h07, 1'b0, 4'b0010, 32'h0);
        dxl("R6 invalid odd write", 32'h1000_7FF0, 8'h07, 1'b1, 4'b0010, 32'h0);
        dxl("R2 past 16K pair", 32'h1000_8000, 8'h07, 1'b0, 4'b0100, 32'h0);
        dxl("R5 1M even", 32'h200F_FFFF, 8'h45, 1'b0, 4'b1000, 32'h400F_FFFF);
        dxl("R4 1M odd", 32'h2010_0010, 8'h45, 1'b1, 4'b1000, 32'h5000_0010);
        dxl("R10 mask bits 31:29 dropped", 32'h0000_0000, 8'h45, 1'b0, 4'b0100, 32'h0);
        dxl("R10 global needs both", 32'h200F_FFFF, 8'h44, 1'b0, 4'b0100, 32'h0);
        dxl("R11 low word junk ignored", 32'h3000_0010, 8'h99, 1'b0, 4'b1000, 32'h0077_7010);
        dxl("R12 lowest entry wins", 32'h3000_1010, 8'h99, 1'b1, 4'b0001, 32'h0);
        dpb("R9 probe 1M", 32'h2000_0045, 32'd9);
        dpb("R9 probe global", 32'h1000_5007, 32'd5);
        dpb("R12 probe lowest", 32'h3000_00AA, 32'd7);
        dpb("R9 probe private", 32'h0040_0001, 32'd3);
        dpb("R9 probe miss", 32'h0040_0002, 32'h8000_0000);
        @(negedge clk);
        chk("R8 no request no response", {63'b0, xl_valid}, 64'd0);

        // Sweeps across and past each mapped region
        bases[0] = 32'h0040_0000; bases[1] = 32'h1000_0000; bases[2] = 32'h2000_0000;
        bases[3] = 32'h3000_0000; bases[4] = 32'h0000_0000;
        asids[0] = 8'h00; asids[1] = 8'h01; asids[2] = 8'h07; asids[3] = 8'h45;
        for (int b = 0; b < 5; b++) begin
            int e;
            logic [31:0] span;
            e = model_match(bases[b], 8'h45);
            if (e < 0) e = model_match(bases[b], 8'h01);
            if (e < 0) e = 0;
            span = (m_pm[e] | 32'h1FFF) + 1;
            for (int k = 0; k < 32; k++) begin
                logic [31:0] a;
                a = bases[b] - span + 32'(k) * (span >> 3) + 32'h0A5;
                for (int s = 0; s < 4; s++) begin
                    logic [31:0] r;
                    int mi;
                    for (int w = 0; w < 2; w++) begin
                        logic [3:0] fl, efl; logic [31:0] pa, epa; logic vld;
                        model_xl(a, asids[s], w[0], efl, epa);
                        xl(a, asids[s], w[0], fl, pa, vld);
                        chk("R8 sweep outcome", {59'b0, vld, fl}, {59'b0, 1'b1, efl});
                        if (efl == 4'b1000) chk("R5 sweep paddr", {32'b0, pa}, {32'b0, epa});
                    end
                    mi = model_match({a[31:8], asids[s]}, asids[s]);
                    pb({a[31:8], asids[s]}, r);
                    chk("R9 sweep probe", {32'b0, r},
                        {32'b0, (mi < 0) ? 32'h8000_0000 : 32'(mi)});
                end
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule